// File: doc/BRIEF.md
# Complementary Mosaic Luma/Chroma Separator

This block sits after the digitizer of a camera whose sensor carries a yellow, cyan, magenta and green color filter mosaic and whose readout sums two vertically adjacent pixels into each sample. It groups the samples of a line into pairs and returns two values for each pair. The luma value is the floor of the pair's mean. The chroma value is the later sample minus the earlier one.

The subtraction order is the same on every line. On lines of the first kind the pairs are (G+Cy, Mg+Ye), so the chroma difference approximates R-Y. On lines of the second kind the pairs are (Mg+Cy, G+Ye), so the chroma difference approximates -(B-Y). The line kind is taken from a parity input when a line starts and is passed out with each result. Downstream logic uses it to route the color difference to the right channel. The same alternation applies in both fields.

A line-start strobe resets the pairing, so each line begins on a new pair. A sample left over at the end of a line is discarded.

Top module: `mlc_sep`

## Requirements
- R1: While rst_ni is low, out_vld_o, y_o, c_o and c_kind_o are all 0.
- R2: For a pair whose first (even-indexed) sample is a and whose second sample is b, y_o = floor((a + b) / 2), over the full 12-bit unsigned input range.
- R3: For the same pair, c_o = b - a as a 13-bit two's-complement value, from -4095 to +4095.
- R4: c_kind_o is the value of line_odd_i captured on the most recent line_start_i. 0 marks an R-Y result and 1 marks a -(B-Y) result. Changes of line_odd_i at any other time have no effect.
- R5: out_vld_o is high for exactly one cycle for each completed pair, in the cycle right after the clock edge that accepts the pair's second sample. It is never high in two consecutive cycles.
- R6: line_start_i returns the pair position to even. A sample accepted with line_start_i is index 0 of the new line. A first sample still held from the previous line is discarded without any output.
- R7: A line with an odd number of samples yields one result per complete pair. Its last sample produces no pulse on out_vld_o.
- R8: Cycles with smp_vld_i low do not advance the pair position. Idle cycles may appear anywhere, including between the two samples of a pair.
- R9: While out_vld_o is low, y_o, c_o and c_kind_o keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 12 | Unsigned two-pixel sum sample |
| smp_vld_i | input | 1 | smp_i holds a sample this cycle |
| line_start_i | input | 1 | First cycle of a new line; may come with a sample |
| line_odd_i | input | 1 | Line kind, sampled with line_start_i |
| y_o | output | 12 | Luma: floor of the pair mean |
| c_o | output | 13 | Chroma: second sample minus first, signed |
| c_kind_o | output | 1 | 0 for R-Y, 1 for -(B-Y) |
| out_vld_o | output | 1 | One-cycle strobe marking a new result |

## Verification
Ramps of typical mosaic levels are fed on both line kinds. These show whether the difference is taken in the fixed order and whether the kind flag follows the latched parity rather than the live input. Extreme pairs (full scale against zero in both orders, equal values, odd sums) probe the sign of the chroma and the truncation of the luma mean. Streams with idle gaps, odd-length lines, restarts in the middle of a pair and start strobes without a sample separate correct pair tracking from tracking that counts cycles or carries state across lines. Random lines with random gaps are then compared against a queue-based model on every clock.

// File: rtl/mlc_pkg.sv
`timescale 1ns/1ps
package mlc_pkg;
  typedef enum logic {
    CK_R_MINUS_Y  = 1'b0,
    CK_NEG_B_MINUS_Y = 1'b1
  } chroma_kind_e;
endpackage

// File: rtl/mlc_line_ctl.sv
`timescale 1ns/1ps
module mlc_line_ctl
  import mlc_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         smp_vld_i,
  input  logic         line_start_i,
  input  logic         line_odd_i,
  output logic         take_first_o,
  output logic         take_second_o,
  output chroma_kind_e kind_o
);
  logic         odd_pos_q;
  logic         eff_odd;
  chroma_kind_e kind_q;

  // a line start forces the current sample to even position
  assign eff_odd       = odd_pos_q & ~line_start_i;
  assign take_first_o  = smp_vld_i & ~eff_odd;
  assign take_second_o = smp_vld_i &  eff_odd;
  assign kind_o        = kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_pos_q <= 1'b0;
      kind_q    <= CK_R_MINUS_Y;
    end else begin
      odd_pos_q <= smp_vld_i ? ~eff_odd : eff_odd;
      if (line_start_i) kind_q <= chroma_kind_e'(line_odd_i);
    end
  end
endmodule

// File: rtl/mlc_hold.sv
`timescale 1ns/1ps
module mlc_hold #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/mlc_combine.sv
`timescale 1ns/1ps
module mlc_combine #(
  parameter int unsigned SMP_W = 12,
  localparam int unsigned C_W  = SMP_W + 1
) (
  input  logic [SMP_W-1:0]      first_i,
  input  logic [SMP_W-1:0]      second_i,
  output logic [SMP_W-1:0]      y_o,
  output logic signed [C_W-1:0] c_o
);
  logic [C_W-1:0] sum;

  always_comb begin
    sum = {1'b0, first_i} + {1'b0, second_i};
    y_o = sum[C_W-1:1];
    c_o = $signed({1'b0, second_i}) - $signed({1'b0, first_i});
  end
endmodule

// File: rtl/mlc_sep.sv
`timescale 1ns/1ps
module mlc_sep
  import mlc_pkg::*;
#(
  parameter int unsigned SMP_W = 12,
  localparam int unsigned C_W  = SMP_W + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SMP_W-1:0]      smp_i,
  input  logic                  smp_vld_i,
  input  logic                  line_start_i,
  input  logic                  line_odd_i,
  output logic [SMP_W-1:0]      y_o,
  output logic signed [C_W-1:0] c_o,
  output logic                  c_kind_o,
  output logic                  out_vld_o
);
  logic                  take_first, take_second;
  chroma_kind_e          kind;
  logic [SMP_W-1:0]      first_q;
  logic [SMP_W-1:0]      y_d;
  logic signed [C_W-1:0] c_d;

  mlc_line_ctl u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .smp_vld_i    (smp_vld_i),
    .line_start_i (line_start_i),
    .line_odd_i   (line_odd_i),
    .take_first_o (take_first),
    .take_second_o(take_second),
    .kind_o       (kind)
  );

  mlc_hold #(.W(SMP_W)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(take_first),
    .d_i   (smp_i),
    .q_o   (first_q)
  );

  mlc_combine #(.SMP_W(SMP_W)) u_comb (
    .first_i (first_q),
    .second_i(smp_i),
    .y_o     (y_d),
    .c_o     (c_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o       <= '0;
      c_o       <= '0;
      c_kind_o  <= 1'b0;
      out_vld_o <= 1'b0;
    end else begin
      out_vld_o <= take_second;
      if (take_second) begin
        y_o      <= y_d;
        c_o      <= c_d;
        c_kind_o <= kind;
      end
    end
  end
endmodule

// File: rtl/mlc_sep_chk.sv
`timescale 1ns/1ps
module mlc_sep_chk #(
  parameter int unsigned SMP_W = 12,
  localparam int unsigned C_W  = SMP_W + 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  smp_vld_i,
  input logic                  line_start_i,
  input logic [SMP_W-1:0]      y_o,
  input logic signed [C_W-1:0] c_o,
  input logic                  c_kind_o,
  input logic                  out_vld_o
);
  localparam int MAX2 = 2 * ((1 << SMP_W) - 1);
  int b2, a2;
  always_comb begin
    b2 = 2 * int'(y_o) + int'(c_o) + int'(c_o[0]);
    a2 = 2 * int'(y_o) - int'(c_o) + int'(c_o[0]);
  end

  a_r2_pair_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> (b2 >= 0 && b2 <= MAX2 && a2 >= 0 && a2 <= MAX2));
  a_r5_after_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_vld_o) |-> $past(smp_vld_i, 1));
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |=> !out_vld_o);
  a_r6_no_result_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_vld_o) |-> !$past(line_start_i, 1));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_vld_o |-> ($stable(y_o) && $stable(c_o) && $stable(c_kind_o)));
endmodule

bind mlc_sep mlc_sep_chk #(.SMP_W(SMP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_vld_i   (smp_vld_i),
  .line_start_i(line_start_i),
  .y_o         (y_o),
  .c_o         (c_o),
  .c_kind_o    (c_kind_o),
  .out_vld_o   (out_vld_o)
);

// File: tb/mlc_sep_tb_top.sv
`timescale 1ns/1ps
module mlc_sep_tb_top;
  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [11:0]        smp_i = '0;
  logic               smp_vld_i = 1'b0;
  logic               line_start_i = 1'b0;
  logic               line_odd_i = 1'b0;
  logic [11:0]        y_o;
  logic signed [12:0] c_o;
  logic               c_kind_o;
  logic               out_vld_o;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;
  string vld_tag = "R5";
  int lcg = 12345;

  // reference model state
  int q_first[$];
  int m_par = 0;
  int e_y = 0, e_c = 0, e_k = 0;
  bit e_v = 1'b0;

  always #5 clk_i = ~clk_i;

  mlc_sep dut_i (.*);

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_first.delete(); m_par = 0; e_y = 0; e_c = 0; e_k = 0; e_v = 1'b0;
    end else begin
      e_v = 1'b0;
      if (line_start_i) begin
        q_first.delete();
        m_par = int'(line_odd_i);
      end
      if (smp_vld_i) begin
        if (q_first.size() == 0) q_first.push_back(int'(smp_i));
        else begin
          int a;
          a = q_first.pop_front();
          e_y = (a + int'(smp_i)) / 2;
          e_c = int'(smp_i) - a;
          e_k = m_par;
          e_v = 1'b1;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      string t;
      checks++;
      if (out_vld_o) pulses++;
      t = e_v ? "" : " R9";
      if (out_vld_o !== e_v) begin
        errors++; $display("FAIL %s out_vld_o act %0b exp %0b", vld_tag, out_vld_o, e_v);
      end else if (int'(y_o) != e_y) begin
        errors++; $display("FAIL R2%s y_o act %0d exp %0d", t, y_o, e_y);
      end else if (int'(c_o) != e_c) begin
        errors++; $display("FAIL R3%s c_o act %0d exp %0d", t, c_o, e_c);
      end else if (int'(c_kind_o) != e_k) begin
        errors++; $display("FAIL R4%s c_kind_o act %0b exp %0d", t, c_kind_o, e_k);
      end
    end
  end

  task automatic drive(input bit v, input int s, input bit st, input bit odd);
    @(negedge clk_i);
    smp_vld_i = v; smp_i = 12'(s); line_start_i = st; line_odd_i = odd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 1'b0, line_odd_i);
  endtask

  task automatic line(input bit odd, input int n, input int base, input int step);
    for (int i = 0; i < n; i++) drive(1'b1, (base + i * step) % 4096, i == 0, (i == 0) ? odd : ~odd);
  endtask

  function automatic int rnd(input int m);
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return (lcg >>> 8) % m;
  endfunction

  task automatic check_pulses(input string tag, input int exp);
    checks++;
    if (pulses != exp) begin
      errors++; $display("FAIL %s pulse count act %0d exp %0d", tag, pulses, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    checks++;
    if (out_vld_o !== 1'b0 || y_o !== '0 || c_o !== '0 || c_kind_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 act vld %0b y %0d c %0d k %0b exp 0 0 0 0", out_vld_o, y_o, c_o, c_kind_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;

    // R2 R3 R4: both line kinds, live line_odd_i toggled mid-line
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, 300, 1'b1, k[0]);   drive(1'b1, 900, 1'b0, ~k[0]);
      drive(1'b1, 310, 1'b0, ~k[0]);  drive(1'b1, 950, 1'b0, ~k[0]);
      drive(1'b1, 1200, 1'b0, ~k[0]); drive(1'b1, 700, 1'b0, ~k[0]);
      idle(2);
    end
    // extremes
    drive(1'b1, 4095, 1'b1, 1'b0); drive(1'b1, 0, 1'b0, 1'b0);
    drive(1'b1, 0, 1'b0, 1'b0);    drive(1'b1, 4095, 1'b0, 1'b0);
    drive(1'b1, 4095, 1'b0, 1'b0); drive(1'b1, 4095, 1'b0, 1'b0);
    drive(1'b1, 1, 1'b0, 1'b0);    drive(1'b1, 2, 1'b0, 1'b0);
    drive(1'b1, 0, 1'b0, 1'b0);    drive(1'b1, 0, 1'b0, 1'b0);
    idle(3);

    // R8 gaps, including within a pair; R4 start strobe without sample
    vld_tag = "R8";
    drive(1'b0, 0, 1'b1, 1'b1); idle(2);
    drive(1'b1, 100, 1'b0, 1'b0); idle(3); drive(1'b1, 800, 1'b0, 1'b0);
    idle(1); drive(1'b1, 50, 1'b0, 1'b0); drive(1'b1, 60, 1'b0, 1'b1); idle(2);
    idle(2);

    // R7 odd-length line: 5 samples give 2 results
    vld_tag = "R7";
    pulses = 0;
    line(1'b0, 5, 1000, 333);
    idle(4);
    check_pulses("R7", 2);
    pulses = 0;
    line(1'b1, 4, 2000, 77);  // next line pairs from its own first sample
    idle(3);
    check_pulses("R7", 2);

    // R6 restart in mid-pair discards held sample
    vld_tag = "R6";
    pulses = 0;
    drive(1'b1, 4000, 1'b1, 1'b0);
    drive(1'b1, 10, 1'b1, 1'b1); drive(1'b1, 30, 1'b0, 1'b1);
    idle(3);
    check_pulses("R6", 1);
    pulses = 0;
    drive(1'b1, 500, 1'b1, 1'b0); drive(1'b0, 0, 1'b1, 1'b1);
    drive(1'b1, 20, 1'b0, 1'b0);  drive(1'b1, 25, 1'b0, 1'b0);
    idle(3);
    check_pulses("R6", 1);

    // random lines with gaps, compared every clock
    vld_tag = "R5";
    for (int l = 0; l < 60; l++) begin
      int n;
      n = 1 + rnd(14);
      for (int i = 0; i < n; i++) begin
        if (rnd(4) == 0) drive(1'b0, rnd(4096), 1'b0, rnd(2) == 1);
        drive(1'b1, rnd(4096), i == 0, rnd(2) == 1);
      end
      idle(rnd(3));
    end
    idle(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R5 act hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule